// File: doc/BRIEF.md
# Windowed Absolute-Difference Disparity Search

This block finds the disparity of one reference pixel in a rectified stereo pair. A start pulse loads a 5×5 window of 8-bit pixels taken from the left image. After that the block accepts one candidate window from the right image on each cycle in which the valid strobe is high. The candidate windows are shifted along the same row, and the first candidate accepted after a start is shift 0. For every candidate the block forms 25 absolute differences in parallel and adds them into one matching cost.

A comparator keeps a running winner. When a new cost is strictly smaller than the cost held so far, the new cost and its shift index replace the held pair. After the 64th candidate the block raises a one-cycle done strobe. The disparity output and the minimum-cost output then hold their values until the next search accepts its first candidate. Row buffering and writing the result out are left to the surrounding logic, which feeds one candidate window per shift.

Top module: `sad_wta_engine`

## Requirements
- R1: Synchronous active-high reset drives `done`, `disparity` and `minCost` to 0.
- R2: A `start` pulse captures `leftWin`. The next `NUM_DISP` (64) cycles with `rightValid` high are candidates with shift indices 0, 1, … 63, in that order. A `rightValid` in the same cycle as `start` is not a candidate. Pixel i occupies bits [8i+7:8i] of each window vector.
- R3: A candidate's cost is the sum over the 25 pixel positions of |left − right|, held in 13 bits without loss. The largest cost, 25 × 255 = 6375, is reported exactly.
- R4: When the search ends, `disparity` (8 bits, zero-extended) is the shift index of the smallest cost and `minCost` is that cost.
- R5: When costs are equal, the smaller shift index wins. A later equal cost never moves the winner.
- R6: `done` is high for exactly one cycle: the cycle after the 64th candidate is accepted, with the final `disparity` and `minCost` already on the outputs. Both outputs hold their values while no candidate is accepted.
- R7: `rightValid` has no effect when no search is active: after reset before any start, or after a search has completed.
- R8: Cycles with `rightValid` low inside a search do not advance the shift index.
- R9: A `start` during a search discards it. The new search begins again at shift 0 with the new left window.
- R10: A candidate identical to the left window gives cost 0 and wins over every nonzero cost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a search and capture the left window |
| leftWin | input | 200 | 25 left-window pixels, pixel i at bits [8i+7:8i] |
| rightValid | input | 1 | rightWin carries the next candidate |
| rightWin | input | 200 | 25 candidate pixels, same layout as leftWin |
| disparity | output | 8 | Shift index of the best candidate |
| minCost | output | 13 | Cost of the best candidate |
| done | output | 1 | One-cycle pulse when the search completes |

## Verification
Pseudo-random windows exercise the cost sum and the running minimum over arbitrary data. A single exact match in the middle of the range separates a true strict-minimum search from an off-by-one index. Searches with all costs equal, and with two equal minima, show whether the tie rule keeps the earlier shift. All-zero against all-255 windows show whether the cost register saturates or truncates. Gapped valid strobes, strobes outside a search and a restart part-way through a search separate correct index counting from counting that depends on strobe timing.

// File: rtl/sad_wta_pkg.sv
package sad_wta_pkg;
  typedef struct packed {
    logic loadLeft;
    logic take;
    logic first;
  } sad_strobe_t;
endpackage

// File: rtl/sad_wta_ctrl.sv
module sad_wta_ctrl
  import sad_wta_pkg::*;
#(
  parameter int NUM_DISP = 64,
  localparam int IDX_W = $clog2(NUM_DISP)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             rightValid,
  output sad_strobe_t      strobe,
  output logic [IDX_W-1:0] candIdx,
  output logic             done
);
  localparam logic [IDX_W-1:0] LastIdx = IDX_W'(NUM_DISP - 1);

  logic busy;
  logic take;

  assign take = rightValid && busy && !start;

  always_comb begin
    strobe.loadLeft = start;
    strobe.take     = take;
    strobe.first    = take && (candIdx == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      candIdx <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy    <= 1'b1;
        candIdx <= '0;
      end else if (take) begin
        candIdx <= candIdx + 1'b1;
        if (candIdx == LastIdx) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  // R6: done never lasts two cycles
  a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R6: done only follows an accepted candidate
  a_r6_done_after_take: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(strobe.take));

  // R9: a start always rewinds the shift index
  a_r9_restart_zero: assert property (@(posedge clk) disable iff (rst)
    start |=> candIdx == '0);
endmodule

// File: rtl/sad_wta_datapath.sv
module sad_wta_datapath
  import sad_wta_pkg::*;
#(
  parameter int PIX_W    = 8,
  parameter int WIN_PIX  = 25,
  parameter int NUM_DISP = 64,
  parameter int DISP_W   = 8,
  localparam int IDX_W   = $clog2(NUM_DISP),
  localparam int COST_W  = PIX_W + $clog2(WIN_PIX),
  localparam int VEC_W   = WIN_PIX * PIX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  sad_strobe_t       strobe,
  input  logic [IDX_W-1:0]  candIdx,
  input  logic [VEC_W-1:0]  leftWin,
  input  logic [VEC_W-1:0]  rightWin,
  output logic [DISP_W-1:0] bestDisp,
  output logic [COST_W-1:0] bestCost
);
  logic [PIX_W-1:0]  leftReg [WIN_PIX];
  logic [PIX_W:0]    absDiff [WIN_PIX];
  logic [COST_W-1:0] candCost;
  logic              selNew;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < WIN_PIX; i++) leftReg[i] <= '0;
    end else if (strobe.loadLeft) begin
      for (int i = 0; i < WIN_PIX; i++) leftReg[i] <= leftWin[i*PIX_W +: PIX_W];
    end
  end

  // one subtract, then negate when the sign bit is set
  for (genvar g = 0; g < WIN_PIX; g++) begin : g_absdiff
    logic [PIX_W:0] rawDiff;
    assign rawDiff = {1'b0, leftReg[g]} - {1'b0, rightWin[g*PIX_W +: PIX_W]};
    assign absDiff[g] = rawDiff[PIX_W] ? (~rawDiff + 1'b1) : rawDiff;
  end

  always_comb begin
    candCost = '0;
    for (int i = 0; i < WIN_PIX; i++) candCost = candCost + COST_W'(absDiff[i]);
  end

  // strict less-than: equal costs keep the earlier shift
  assign selNew = strobe.first || (candCost < bestCost);

  always_ff @(posedge clk) begin
    if (rst) begin
      bestCost <= '0;
      bestDisp <= '0;
    end else if (strobe.take && selNew) begin
      bestCost <= candCost;
      bestDisp <= DISP_W'(candIdx);
    end
  end

  // R6: result holds while nothing is accepted
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    !strobe.take |=> $stable(bestCost) && $stable(bestDisp));

  // R4: the held minimum never grows within a search
  a_r4_nonincrease: assert property (@(posedge clk) disable iff (rst)
    strobe.take && !strobe.first |=> bestCost <= $past(bestCost));

  // R5: an equal cost leaves the winner in place
  a_r5_tie_keeps: assert property (@(posedge clk) disable iff (rst)
    strobe.take && !strobe.first && (candCost == bestCost) |=> $stable(bestDisp));

  // R2: the first candidate is shift zero
  a_r2_first_zero: assert property (@(posedge clk) disable iff (rst)
    strobe.take && strobe.first |=> bestDisp == '0);
endmodule

// File: rtl/sad_wta_engine.sv
module sad_wta_engine
  import sad_wta_pkg::*;
#(
  parameter int PIX_W    = 8,
  parameter int WIN_PIX  = 25,
  parameter int NUM_DISP = 64,
  parameter int DISP_W   = 8,
  localparam int IDX_W   = $clog2(NUM_DISP),
  localparam int COST_W  = PIX_W + $clog2(WIN_PIX),
  localparam int VEC_W   = WIN_PIX * PIX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [VEC_W-1:0]  leftWin,
  input  logic              rightValid,
  input  logic [VEC_W-1:0]  rightWin,
  output logic [DISP_W-1:0] disparity,
  output logic [COST_W-1:0] minCost,
  output logic              done
);
  sad_strobe_t      strobe;
  logic [IDX_W-1:0] candIdx;

  sad_wta_ctrl #(.NUM_DISP(NUM_DISP)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .rightValid(rightValid),
    .strobe(strobe), .candIdx(candIdx), .done(done)
  );

  sad_wta_datapath #(
    .PIX_W(PIX_W), .WIN_PIX(WIN_PIX), .NUM_DISP(NUM_DISP), .DISP_W(DISP_W)
  ) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .candIdx(candIdx),
    .leftWin(leftWin), .rightWin(rightWin),
    .bestDisp(disparity), .bestCost(minCost)
  );
endmodule

// File: tb/sad_wta_engine_bench.sv
module sad_wta_engine_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NPIX = 25;
  localparam int NDISP = 64;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic         rightValid = 1'b0;
  logic [199:0] leftWin = '0;
  logic [199:0] rightWin = '0;
  logic [7:0]   disparity;
  logic [12:0]  minCost;
  logic         done;

  int checks = 0;
  int errors = 0;

  sad_wta_engine u_sad_wta_engine (
    .clk(clk), .rst(rst), .start(start), .leftWin(leftWin),
    .rightValid(rightValid), .rightWin(rightWin),
    .disparity(disparity), .minCost(minCost), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int mBusy, mCnt, mDone, mDisp, mCost, mc;
  int mLeft [NPIX];
  always @(posedge clk) begin
    if (rst) begin
      mBusy = 0; mCnt = 0; mDone = 0; mDisp = 0; mCost = 0;
    end else begin
      mDone = 0;
      if (start) begin
        mBusy = 1; mCnt = 0;
        for (int i = 0; i < NPIX; i++) mLeft[i] = int'(leftWin[i*8 +: 8]);
      end else if (rightValid && mBusy != 0) begin
        mc = 0;
        for (int i = 0; i < NPIX; i++) begin
          int d;
          d = mLeft[i] - int'(rightWin[i*8 +: 8]);
          mc += (d < 0) ? -d : d;
        end
        if (mCnt == 0 || mc < mCost) begin mCost = mc; mDisp = mCnt; end
        if (mCnt == NDISP - 1) begin mBusy = 0; mDone = 1; end
        mCnt++;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      check(int'(done) == mDone, "R6 done vs model", int'(done), mDone);
      check(int'(disparity) == mDisp, "R4 disparity vs model", int'(disparity), mDisp);
      check(int'(minCost) == mCost, "R3 minCost vs model", int'(minCost), mCost);
    end
  end

  function automatic logic [7:0] hashPix(int a, int b);
    int h;
    h = (a * 131 + b * 57 + 17) ^ ((a * b) >> 3);
    return 8'(h * 29);
  endfunction

  function automatic logic [7:0] pixL(int mode, int i, int seed);
    if (mode == 4) return 8'h00;
    return hashPix(i, seed);
  endfunction

  function automatic logic [7:0] pixR(int mode, int k, int i, int seed);
    logic [7:0] l;
    l = pixL(mode, i, seed);
    case (mode)
      1: return (k == 37) ? l : (l ^ 8'h10);
      2: return l ^ 8'h01;
      3: return (k == 10 || k == 50) ? (l ^ 8'h01) : (l ^ 8'h04);
      4: return 8'hFF;
      default: return hashPix(k * 25 + i, seed + 3);
    endcase
  endfunction

  task automatic loadRight(int mode, int k, int seed);
    for (int i = 0; i < NPIX; i++) rightWin[i*8 +: 8] = pixR(mode, k, i, seed);
  endtask

  task automatic beginSearch(int mode, int seed);
    @(negedge clk);
    start = 1'b1;
    rightValid = 1'b1;
    loadRight(mode, 0, seed);
    for (int i = 0; i < NPIX; i++) leftWin[i*8 +: 8] = pixL(mode, i, seed);
    @(negedge clk);
    start = 1'b0;
    rightValid = 1'b0;
  endtask

  task automatic runSearch(int mode, int seed, bit gaps, int expDisp, int expCost, string tag);
    beginSearch(mode, seed);
    for (int k = 0; k < NDISP; k++) begin
      rightValid = 1'b1;
      loadRight(mode, k, seed);
      @(negedge clk);
      if (gaps && (k % 3 == 1)) begin
        rightValid = 1'b0;
        loadRight(1, 37, seed);
        @(negedge clk);
        check(done == 1'b0, {tag, " no done during gap"}, int'(done), 0);
      end
    end
    rightValid = 1'b0;
    check(done == 1'b1, {tag, " R6 done after last"}, int'(done), 1);
    if (expDisp >= 0) begin
      check(int'(disparity) == expDisp, {tag, " disparity"}, int'(disparity), expDisp);
      check(int'(minCost) == expCost, {tag, " minCost"}, int'(minCost), expCost);
    end
    @(negedge clk);
    check(done == 1'b0, {tag, " R6 done one cycle"}, int'(done), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; errors++;
    $display("FAIL R6 watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(done == 1'b0, "R1 reset done", int'(done), 0);
    check(disparity == 8'd0, "R1 reset disparity", int'(disparity), 0);
    check(minCost == 13'd0, "R1 reset minCost", int'(minCost), 0);
    rst = 1'b0;

    // R7: strobes before any start change nothing
    rightValid = 1'b1;
    loadRight(4, 0, 0);
    repeat (4) @(negedge clk);
    rightValid = 1'b0;
    check(minCost == 13'd0 && done == 1'b0, "R7 idle valid ignored", int'(minCost), 0);

    runSearch(0, 5, 1'b0, -1, 0, "R2 random");
    runSearch(0, 11, 1'b0, -1, 0, "R4 random");
    runSearch(1, 2, 1'b0, 37, 0, "R10 exact match");

    // R7: strobes after completion are ignored
    rightValid = 1'b1;
    loadRight(2, 5, 2);
    repeat (5) @(negedge clk);
    rightValid = 1'b0;
    check(int'(disparity) == 37, "R7 post-done disparity", int'(disparity), 37);
    check(int'(minCost) == 0, "R7 post-done minCost", int'(minCost), 0);
    check(done == 1'b0, "R7 post-done done", int'(done), 0);

    runSearch(2, 7, 1'b0, 0, 25, "R5 all equal");
    runSearch(3, 9, 1'b0, 10, 25, "R5 two minima");
    runSearch(4, 0, 1'b0, 0, 6375, "R3 max cost");
    runSearch(3, 4, 1'b1, 10, 25, "R8 gapped");

    // R9: abandon a search part-way and restart
    beginSearch(0, 21);
    for (int k = 0; k < 20; k++) begin
      rightValid = 1'b1;
      loadRight(0, k, 21);
      @(negedge clk);
    end
    rightValid = 1'b0;
    runSearch(1, 8, 1'b0, 37, 0, "R9 restart");

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule